// File: doc/BRIEF.md
# Packetizing DMA Transmit Engine

This engine sits between a tile's local memory and the local input port of its network router. Software queues transfer commands, each naming a starting word address, a length in 32-bit words and a destination. The engine works through its queue in order. It reads the words of a transfer from a memory read port and sends them to the router as a run of packets. Each packet is a four-flit header followed by at most sixteen payload words.

Once the last data word of a transfer has gone out, the engine sends one header-only packet of four flits. This packet tells the receiving tile that the whole transfer has landed. A one-cycle done pulse then marks the end of that command. The processor can queue several commands and carry on working, because up to four of them wait in a small queue.

The memory port is combinational: the word at `mem_addr` must be on `mem_rdata` in the same cycle. The router side is a plain valid/ready flit stream with a tail marker.

Top module: `pkt_dma_tx`

## Requirements
- R1: During reset and in the first cycle after it, `flit_valid`, `mem_rd_en` and `done` are low and `cmd_ready` is high.
- R2: The command queue holds four commands that are waiting. While it is full, `cmd_ready` is low and a presented command is ignored: it produces no flits.
- R3: Each data packet starts with four header flits. H0 = {4'h1, zero pad, destination}. H1 = the payload word count of this packet. H2 = the packet's index within the transfer, counting from 0. H3 = the word offset of its first payload word within the transfer (16 times the index).
- R4: A transfer of s words is cut into ceil(s/16) packets. Every packet except the last carries 16 payload words. The last carries s mod 16 words, or 16 when that remainder is zero. `flit_last` is high only on the final flit of each packet.
- R5: Payload word j of a transfer is the memory word at address `cmd_addr` + j. It is read through `mem_addr` with `mem_rd_en` high.
- R6: After the data of every transfer comes one lock packet of exactly four flits. H0 = {4'h2, zero pad, destination}, H1 = 0, H2 = the number of data packets, H3 = s. `flit_last` is high on the fourth flit.
- R7: A command with length zero produces only the lock packet, with H2 = 0 and H3 = 0.
- R8: With `flit_ready` held high, all s + ceil(s/16)*4 + 4 flits of a transfer go out in consecutive cycles.
- R9: While `flit_valid` is high and `flit_ready` is low, the presented flit and its tail marker stay unchanged. No flit is lost or sent twice.
- R10: `done` is high for exactly one cycle, in the cycle after the lock packet's tail flit is accepted. It pulses once per command.
- R11: Commands are served in the order they were accepted, and the flits of two transfers never interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The queue can take a command |
| cmd_addr | input | ADDR_W | First word address of the transfer |
| cmd_len | input | LEN_W | Transfer length in words |
| cmd_dest | input | DEST_W | Destination written into each header |
| mem_rd_en | output | 1 | A payload word is being read |
| mem_addr | output | ADDR_W | Word address being read |
| mem_rdata | input | 32 | Word at `mem_addr`, same cycle |
| flit_valid | output | 1 | A flit is presented to the router |
| flit_ready | input | 1 | The router takes the flit this cycle |
| flit_data | output | 32 | Flit contents |
| flit_last | output | 1 | Final flit of a packet |
| done | output | 1 | One-cycle pulse when a command has finished |

## Verification
The hardest state to reach is a full command queue whose fifth command is turned away. The engine drains the queue as soon as it can, so the queue fills only while the output is stalled. The stimulus therefore holds `flit_ready` low and pushes five commands: one is taken by the engine and four fill the queue. It then offers one more command for several cycles. Because the bench builds every flit it expects from its own list of accepted commands, a wrongly accepted extra command shows up as surplus flits once the output is released. Random backpressure across the packet and lock boundaries covers the stall-hold rule.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int FLIT_W = 32;
  localparam int KIND_W = 4;
  localparam logic [KIND_W-1:0] KIND_DATA = 4'h1;
  localparam logic [KIND_W-1:0] KIND_LOCK = 4'h2;
  localparam int HDR_FLITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DHDR = 2'd1,
    ST_DPAY = 2'd2,
    ST_LOCK = 2'd3
  } pdt_state_e;
endpackage

// File: rtl/pdt_cmd_fifo.sv
module pdt_cmd_fifo #(
  parameter int W     = 44,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = ptr_inc(wr_q);
    if (pop)  rd_d = ptr_inc(rd_q);
    if (push && !pop) cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= din;
  end

  assign dout  = store[rd_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  // R11: the engine only takes a command that is actually queued
  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R2: occupancy never passes the depth
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/pdt_seg_calc.sv
module pdt_seg_calc #(
  parameter int LEN_W   = 12,
  parameter int MAX_PAY = 16,
  parameter int PAY_W   = 5
) (
  input  logic [LEN_W-1:0] words_left,
  output logic [PAY_W-1:0] pkt_pay
);
  always_comb begin
    if (words_left >= LEN_W'(MAX_PAY)) pkt_pay = PAY_W'(MAX_PAY);
    else                              pkt_pay = words_left[PAY_W-1:0];
  end

  // R4: a non-empty remainder always yields a packet of 1..MAX_PAY words
  always_comb begin
    if (words_left != '0)
      assert_pay_range_R4: assert (pkt_pay != '0 && pkt_pay <= PAY_W'(MAX_PAY));
  end
endmodule

// File: rtl/pdt_hdr_gen.sv
module pdt_hdr_gen
  import pdt_pkg::*;
#(
  parameter int DEST_W = 16,
  parameter int LEN_W  = 12,
  parameter int PAY_W  = 5
) (
  input  logic              is_lock,
  input  logic [1:0]        sel,
  input  logic [DEST_W-1:0] dest,
  input  logic [PAY_W-1:0]  pay,
  input  logic [LEN_W-1:0]  pkt_idx,
  input  logic [LEN_W-1:0]  word_ofs,
  input  logic [LEN_W-1:0]  total,
  output logic [FLIT_W-1:0] word
);
  localparam int PAD_W = FLIT_W - KIND_W - DEST_W;

  logic [KIND_W-1:0] kind;
  assign kind = is_lock ? KIND_LOCK : KIND_DATA;

  always_comb begin
    unique case (sel)
      2'd0: word = {kind, {PAD_W{1'b0}}, dest};
      2'd1: word = is_lock ? '0 : {{(FLIT_W-PAY_W){1'b0}}, pay};
      2'd2: word = {{(FLIT_W-LEN_W){1'b0}}, pkt_idx};
      default: word = {{(FLIT_W-LEN_W){1'b0}}, (is_lock ? total : word_ofs)};
    endcase
  end
endmodule

// File: rtl/pkt_dma_tx.sv
module pkt_dma_tx
  import pdt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int DEST_W     = 16,
  parameter int QUEUE_DEPTH = 4,
  parameter int MAX_PAY    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DEST_W-1:0] cmd_dest,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              flit_valid,
  input  logic              flit_ready,
  output logic [31:0]       flit_data,
  output logic              flit_last,
  output logic              done
);
  localparam int CMD_W = ADDR_W + LEN_W + DEST_W;
  localparam int PAY_W = $clog2(MAX_PAY + 1);
  localparam logic [1:0] HDR_END = 2'(HDR_FLITS - 1);

  // command queue
  logic             q_push, q_pop, q_full, q_empty;
  logic [CMD_W-1:0] q_head;
  logic [ADDR_W-1:0] h_addr;
  logic [LEN_W-1:0]  h_len;
  logic [DEST_W-1:0] h_dest;

  assign q_push    = cmd_valid && !q_full;
  assign cmd_ready = !q_full;
  assign {h_addr, h_len, h_dest} = q_head;

  pdt_cmd_fifo #(.W(CMD_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   ({cmd_addr, cmd_len, cmd_dest}),
    .pop   (q_pop),
    .dout  (q_head),
    .full  (q_full),
    .empty (q_empty)
  );

  // state
  pdt_state_e        state_q, state_d;
  logic [1:0]        hcnt_q, hcnt_d;
  logic [PAY_W-1:0]  pcnt_q, pcnt_d;
  logic [PAY_W-1:0]  cpay_q, cpay_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  pidx_q, pidx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic              done_q, done_d;

  // packet sizing
  logic [LEN_W-1:0] seg_in;
  logic [PAY_W-1:0] seg_pay;
  assign seg_in = (state_q == ST_IDLE) ? h_len : rem_q - LEN_W'(1);

  pdt_seg_calc #(.LEN_W(LEN_W), .MAX_PAY(MAX_PAY), .PAY_W(PAY_W)) u_seg (
    .words_left (seg_in),
    .pkt_pay    (seg_pay)
  );

  // header words
  logic [31:0] hdr_word;
  pdt_hdr_gen #(.DEST_W(DEST_W), .LEN_W(LEN_W), .PAY_W(PAY_W)) u_hdr (
    .is_lock  (state_q == ST_LOCK),
    .sel      (hcnt_q),
    .dest     (dest_q),
    .pay      (cpay_q),
    .pkt_idx  (pidx_q),
    .word_ofs (len_q - rem_q),
    .total    (len_q),
    .word     (hdr_word)
  );

  logic pay_end;
  assign pay_end = (pcnt_q == cpay_q - PAY_W'(1));

  // next state
  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    pcnt_d  = pcnt_q;
    cpay_d  = cpay_q;
    rem_d   = rem_q;
    len_d   = len_q;
    pidx_d  = pidx_q;
    addr_d  = addr_q;
    dest_d  = dest_q;
    done_d  = 1'b0;
    q_pop   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!q_empty) begin
          q_pop   = 1'b1;
          addr_d  = h_addr;
          len_d   = h_len;
          rem_d   = h_len;
          dest_d  = h_dest;
          pidx_d  = '0;
          hcnt_d  = '0;
          pcnt_d  = '0;
          cpay_d  = seg_pay;
          state_d = (h_len == '0) ? ST_LOCK : ST_DHDR;
        end
      end
      ST_DHDR: begin
        if (flit_ready) begin
          hcnt_d = hcnt_q + 2'd1;
          if (hcnt_q == HDR_END) begin
            pcnt_d  = '0;
            state_d = ST_DPAY;
          end
        end
      end
      ST_DPAY: begin
        if (flit_ready) begin
          addr_d = addr_q + ADDR_W'(1);
          rem_d  = rem_q - LEN_W'(1);
          pcnt_d = pcnt_q + PAY_W'(1);
          if (pay_end) begin
            pidx_d = pidx_q + LEN_W'(1);
            hcnt_d = '0;
            if (rem_q == LEN_W'(1)) begin
              state_d = ST_LOCK;
            end else begin
              cpay_d  = seg_pay;
              state_d = ST_DHDR;
            end
          end
        end
      end
      default: begin
        if (flit_ready) begin
          hcnt_d = hcnt_q + 2'd1;
          if (hcnt_q == HDR_END) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      pcnt_q  <= '0;
      cpay_q  <= '0;
      rem_q   <= '0;
      len_q   <= '0;
      pidx_q  <= '0;
      addr_q  <= '0;
      dest_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      pcnt_q  <= pcnt_d;
      cpay_q  <= cpay_d;
      rem_q   <= rem_d;
      len_q   <= len_d;
      pidx_q  <= pidx_d;
      addr_q  <= addr_d;
      dest_q  <= dest_d;
      done_q  <= done_d;
    end
  end

  // outputs
  assign flit_valid = (state_q != ST_IDLE);
  assign mem_rd_en  = (state_q == ST_DPAY);
  assign mem_addr   = addr_q;
  assign flit_data  = (state_q == ST_DPAY) ? mem_rdata : hdr_word;
  assign flit_last  = ((state_q == ST_DPAY) && pay_end) ||
                      ((state_q == ST_LOCK) && (hcnt_q == HDR_END));
  assign done       = done_q;

  // R9: a stalled flit is held unchanged
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && !flit_ready |=> flit_valid && $stable(flit_data) && $stable(flit_last));
  // R10: done lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: done follows an accepted lock tail
  assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state_q == ST_LOCK && flit_ready && flit_last));
  // R4: payload counter stays inside the packet size
  assert_pay_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DPAY |-> pcnt_q < cpay_q && cpay_q <= PAY_W'(MAX_PAY));
endmodule

// File: tb/pkt_dma_tx_test.sv
`timescale 1ns/1ps
module pkt_dma_tx_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [15:0] cmd_addr;
  logic [11:0] cmd_len;
  logic [15:0] cmd_dest;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        flit_valid;
  logic        flit_ready;
  logic [31:0] flit_data;
  logic        flit_last;
  logic        done;

  always #2.5 clk = ~clk;

  pkt_dma_tx uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_dest(cmd_dest),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data), .flit_last(flit_last), .done(done)
  );

  // bench memory: word at address a
  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {~a, a};
  endfunction
  assign mem_rdata = mem_word(mem_addr);

  // vectors: address, length, destination, ready mode, expected flit total
  localparam int NV = 8;
  localparam logic [15:0] V_ADDR [NV] = '{16'h0100, 16'h0200, 16'h0300, 16'h0400,
                                         16'h0500, 16'h0600, 16'h0700, 16'hFFF8};
  localparam logic [11:0] V_LEN  [NV] = '{12'd1, 12'd16, 12'd17, 12'd32,
                                         12'd0, 12'd33, 12'd5, 12'd20};
  localparam logic [15:0] V_DEST [NV] = '{16'h0011, 16'h0102, 16'h0203, 16'h0304,
                                         16'h0405, 16'h0506, 16'h0607, 16'h0708};
  localparam int          V_MODE [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};
  localparam int          V_EXP  [NV] = '{9, 24, 29, 44, 4, 49, 13, 32};

  int checks = 0;
  int fails  = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  // queue of accepted commands
  logic [15:0] q_addr [64];
  logic [11:0] q_len  [64];
  logic [15:0] q_dest [64];
  int q_wr = 0;
  int q_rd = 0;
  int k = 0;
  int done_cnt = 0;
  longint cyc = 0;
  longint start_cyc = 0;
  bit stalled = 0;
  bit done_due = 0;
  bit wd_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int total_flits(input logic [11:0] len);
    int np = (int'(len) + 15) / 16;
    return int'(len) + np * 4 + 4;
  endfunction

  // expected flit {last, data} at index kk of a transfer
  function automatic logic [32:0] exp_flit(input logic [15:0] a, input logic [11:0] len,
                                           input logic [15:0] d, input int kk);
    int np = (int'(len) + 15) / 16;
    int r  = kk;
    for (int p = 0; p < np; p++) begin
      int pay = (p == np - 1) ? int'(len) - 16 * p : 16;
      if (r < 4) begin
        case (r)
          0: return {1'b0, 4'h1, 12'h000, d};
          1: return {1'b0, 32'(pay)};
          2: return {1'b0, 32'(p)};
          default: return {1'b0, 32'(16 * p)};
        endcase
      end
      if (r < 4 + pay) return {(r == 3 + pay), mem_word(a + 16'(16 * p + r - 4))};
      r -= 4 + pay;
    end
    case (r)
      0: return {1'b0, 4'h2, 12'h000, d};
      1: return {1'b0, 32'h0};
      2: return {1'b0, 32'(np)};
      default: return {1'b1, 20'h0, len};
    endcase
  endfunction

  // output monitor, ready driver and watchdog
  always begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    flit_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[1]);
    #1;
    cyc++;
    if (rst_n) begin
      // R10: done exactly one cycle after the lock tail was taken
      check(done == done_due, "R10 done timing", {63'd0, done}, {63'd0, done_due});
      if (done) done_cnt++;
      done_due = 0;
      if (flit_valid && !flit_ready) stalled = 1;
      if (flit_valid && flit_ready) begin
        if (q_rd >= q_wr) begin
          check(0, "R2/R11 flit with no accepted command", {32'd0, flit_data}, 64'd0);
        end else begin
          logic [32:0] e;
          int tot;
          if (k == 0) begin start_cyc = cyc; stalled = 0; end
          e = exp_flit(q_addr[q_rd], q_len[q_rd], q_dest[q_rd], k);
          tot = total_flits(q_len[q_rd]);
          // R3 R4 R5 R6 R7 R11: content and tail marker in order
          check({flit_last, flit_data} == e, "R3-R7/R11 flit content",
                {31'd0, flit_last, flit_data}, {31'd0, e});
          k++;
          if (k == tot) begin
            check(flit_last == 1'b1, "R6 lock tail", {63'd0, flit_last}, 64'd1);
            if (!stalled)
              check(cyc - start_cyc + 1 == tot, "R8 back-to-back",
                    64'(cyc - start_cyc + 1), 64'(tot));
            done_due = 1;
            k = 0;
            q_rd++;
          end
        end
      end
    end
    if (cyc > 150000 && !wd_fail) begin
      wd_fail = 1;
      check(0, "watchdog", 64'(cyc), 64'd150000);
    end
  end

  task automatic enq(input logic [15:0] a, input logic [11:0] l, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_len = l; cmd_dest = d;
    #1;
    while (!cmd_ready && !wd_fail) begin @(negedge clk); #1; end
    q_addr[q_wr] = a; q_len[q_wr] = l; q_dest[q_wr] = d;
    q_wr++;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n && !wd_fail) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_dest = '0;
    flit_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: state during reset
    check(!flit_valid && !done && cmd_ready && !mem_rd_en, "R1 in reset",
          {60'd0, flit_valid, done, cmd_ready, mem_rd_en}, 64'b0010);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    check(!flit_valid && !done && cmd_ready && !mem_rd_en, "R1 after reset",
          {60'd0, flit_valid, done, cmd_ready, mem_rd_en}, 64'b0010);

    // table walk
    for (int i = 0; i < NV; i++) begin
      ready_mode = V_MODE[i];
      enq(V_ADDR[i], V_LEN[i], V_DEST[i]);
      wait_done(i + 1);
      check(total_flits(V_LEN[i]) == V_EXP[i], "R8 table flit total",
            64'(total_flits(V_LEN[i])), 64'(V_EXP[i]));
    end

    // R2: fill the queue while the output is stalled
    ready_mode = 2;
    enq(16'h1000, 12'd3,  16'h0A01);
    enq(16'h1100, 12'd0,  16'h0A02);
    enq(16'h1200, 12'd18, 16'h0A03);
    enq(16'h1300, 12'd2,  16'h0A04);
    enq(16'h1400, 12'd1,  16'h0A05);
    @(negedge clk); #1;
    check(cmd_ready == 1'b0, "R2 full queue", {63'd0, cmd_ready}, 64'd0);
    // R2: a sixth command offered while full must be ignored
    cmd_valid = 1'b1; cmd_addr = 16'hDEAD; cmd_len = 12'd7; cmd_dest = 16'h0BAD;
    repeat (4) @(negedge clk);
    #1;
    check(cmd_ready == 1'b0, "R2 still full", {63'd0, cmd_ready}, 64'd0);
    cmd_valid = 1'b0;
    // R9: release with random backpressure
    ready_mode = 1;
    wait_done(NV + 5);
    ready_mode = 0;
    repeat (40) @(negedge clk);
    #2;
    check(done_cnt == q_wr, "R10 one done per command", 64'(done_cnt), 64'(q_wr));
    check(!flit_valid && k == 0, "R2 no surplus transfer", {63'd0, flit_valid}, 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule